// File: doc/BRIEF.md
# Three-Group Interrupt Priority Encoder

The block gathers interrupt requests from three groups of sources (a small critical group, a main group and a wide peripheral group) and condenses them into one read-only status word. Each group gets its own field in that word: a pending flag and the number of the winning source inside the group. A processor interrupt line is raised whenever any of the three flags is set. The handler reads the word and services critical first, then main, then peripheral.

Main and peripheral sources each have a mask register in which a set bit disables the source. Some peripheral sources can be promoted by fixed parameters. A high-boosted peripheral request occupies a reserved slot of the critical group, and a low-boosted one occupies a reserved slot of the main group. This lets the handler see an urgent peripheral early. It then looks at the peripheral field to find out which peripheral source it is. Software reaches the masks and the status word through a 32-bit register port with a 2-bit word address. Writes are single-cycle and reads are combinational.

Top module: `irq_group_encoder`

## Requirements
- R1: The status word (address 2) carries the critical flag in bit 10 with a 2-bit code in bits 9:8, the main flag in bit 21 with a 5-bit code in bits 20:16, and the peripheral flag in bit 29 with a 5-bit code in bits 28:24. Every other bit reads 0, and a code reads 0 while its flag is clear.
- R2: Within a group, the lowest-numbered slot that is pending and enabled is the one reported.
- R3: Critical inputs 0, 1 and 2 occupy critical slots 0, 1 and 3. Slot 2 is pending exactly when some enabled high-boosted peripheral source is pending.
- R4: Main input i occupies main slot i for i below 4 and slot i+1 otherwise. Main slot 4 is pending when some enabled low-boosted peripheral source is pending.
- R5: The main mask register sits at address 0. Main slot n is disabled by bit 16-n. It resets to 0x00010fff, and bits 31:17 read 0 and ignore writes.
- R6: The peripheral mask register sits at address 1. Peripheral source n is disabled by bit 31-n, and the register resets to 0x7ffffc00.
- R7: Peripheral sources listed in the high-boost parameter (default: source 1) feed critical slot 2. Those listed only in the low-boost parameter (default: source 2) feed main slot 4, which the main mask still gates. The peripheral code picks enabled high-boosted sources first, then low-boosted ones, then the rest, taking the lowest number within each tier.
- R8: A source whose mask bit is set never shows up in any flag or code.
- R9: The processor interrupt output is high exactly when at least one group flag is set. A request or mask change takes effect on the output one clock edge after it is applied.
- R10: Writes to address 2 change nothing, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register word address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| critReq | input | 3 | Critical group requests |
| mainReq | input | 16 | Main group requests |
| perReq | input | 32 | Peripheral group requests |
| cpuIrq | output | 1 | Interrupt line to the processor |

## Verification
The encoder is driven with single sources in each group, with several groups at once (to show that the fields are independent), and with several sources in one group (to show lowest-number selection). The critical and main slot remapping is checked from both sides of the reserved slot. Boosted peripheral requests are shown to appear in the reserved critical and main slots while the peripheral field orders its tiers. Masked patterns, including a masked low-boost slot and everything masked, separate gating from encoding. Directed cases cover the reset values of the masks, the ignored status write, and the one-edge latency of the interrupt line on request and mask changes.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MAIN_MASK = 2'd0,
    ADDR_PER_MASK  = 2'd1,
    ADDR_STATUS    = 2'd2,
    ADDR_SPARE     = 2'd3
  } regAddr_e;

  // Status word layout (decoded by the interrupt handler)
  localparam int CRIT_FLAG_BIT = 10;
  localparam int CRIT_CODE_LSB = 8;
  localparam int CRIT_FIELD_W  = 2;
  localparam int MAIN_FLAG_BIT = 21;
  localparam int MAIN_CODE_LSB = 16;
  localparam int MAIN_FIELD_W  = 5;
  localparam int PER_FLAG_BIT  = 29;
  localparam int PER_CODE_LSB  = 24;
  localparam int PER_FIELD_W   = 5;

  // Reserved slots that carry promoted peripheral requests
  localparam int CRIT_BOOST_SLOT = 2;
  localparam int MAIN_BOOST_SLOT = 4;

  typedef struct packed {
    logic             wrMainMask;
    logic             wrPerMask;
    logic [REG_W-1:0] wdata;
  } regStrobes_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  // Lowest set bit wins; idx is zero when nothing is set.
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_enc_ctrl.sv
module irq_enc_ctrl
  import irq_enc_pkg::*;
#(
  parameter int MAIN_SLOTS = 17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWrEn,
  input  logic [REG_W-1:0]      busWdata,
  output logic [REG_W-1:0]      busRdata,
  input  logic [MAIN_SLOTS-1:0] mainMaskQ,
  input  logic [REG_W-1:0]      perMaskQ,
  input  logic [REG_W-1:0]      statusWord,
  output regStrobes_t           strb
);
  regAddr_e addrDec;
  assign addrDec = regAddr_e'(busAddr);

  always_comb begin
    strb            = '0;
    strb.wdata      = busWdata;
    if (busWrEn) begin
      case (addrDec)
        ADDR_MAIN_MASK: strb.wrMainMask = 1'b1;
        ADDR_PER_MASK:  strb.wrPerMask  = 1'b1;
        default:        ;
      endcase
    end
  end

  always_comb begin
    case (addrDec)
      ADDR_MAIN_MASK: busRdata = REG_W'(mainMaskQ);
      ADDR_PER_MASK:  busRdata = perMaskQ;
      ADDR_STATUS:    busRdata = statusWord;
      default:        busRdata = '0;
    endcase
  end

  // R10: a write to the status address never reaches a mask register
  p_status_ro_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_STATUS) |-> (!strb.wrMainMask && !strb.wrPerMask));
endmodule

// File: rtl/irq_enc_datapath.sv
module irq_enc_datapath
  import irq_enc_pkg::*;
#(
  parameter int              CRIT_N        = 3,
  parameter int              MAIN_N        = 16,
  parameter int              PER_N         = 32,
  parameter logic [PER_N-1:0] HI_BOOST     = 'h2,
  parameter logic [PER_N-1:0] LO_BOOST     = 'h4,
  parameter logic [REG_W-1:0] MAIN_MASK_RST = 32'h0001_0fff,
  parameter logic [REG_W-1:0] PER_MASK_RST  = 32'h7fff_fc00,
  localparam int             MAIN_SLOTS    = MAIN_N + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strb,
  input  logic [CRIT_N-1:0]     critReq,
  input  logic [MAIN_N-1:0]     mainReq,
  input  logic [PER_N-1:0]      perReq,
  output logic [MAIN_SLOTS-1:0] mainMaskQ,
  output logic [REG_W-1:0]      perMaskQ,
  output logic [REG_W-1:0]      statusWord,
  output logic                  cpuIrq
);
  localparam int CRIT_SLOTS = CRIT_N + 1;
  localparam int CRIT_W     = $clog2(CRIT_SLOTS);
  localparam int MAIN_W     = $clog2(MAIN_SLOTS);
  localparam int PER_W      = $clog2(PER_N);

  logic [CRIT_N-1:0] critQ;
  logic [MAIN_N-1:0] mainQ;
  logic [PER_N-1:0]  perQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      critQ     <= '0;
      mainQ     <= '0;
      perQ      <= '0;
      mainMaskQ <= MAIN_MASK_RST[MAIN_SLOTS-1:0];
      perMaskQ  <= PER_MASK_RST;
    end else begin
      critQ <= critReq;
      mainQ <= mainReq;
      perQ  <= perReq;
      if (strb.wrMainMask) mainMaskQ <= strb.wdata[MAIN_SLOTS-1:0];
      if (strb.wrPerMask)  perMaskQ  <= strb.wdata;
    end
  end

  // Peripheral group: mask (bit 31-n), then split into boost tiers
  logic [PER_N-1:0] perLive, hiLive, loLive, normLive;
  for (genvar n = 0; n < PER_N; n++) begin : g_perEn
    assign perLive[n] = perQ[n] & ~perMaskQ[REG_W-1-n];
  end
  assign hiLive   = perLive & HI_BOOST;
  assign loLive   = perLive & LO_BOOST & ~HI_BOOST;
  assign normLive = perLive & ~(HI_BOOST | LO_BOOST);

  logic             hiHit, loHit, normHit;
  logic [PER_W-1:0] hiIdx, loIdx, normIdx, perIdx;
  logic             perHit;

  irq_prio_enc #(.N(PER_N), .W(PER_W)) i_hiEnc   (.req(hiLive),   .hit(hiHit),   .idx(hiIdx));
  irq_prio_enc #(.N(PER_N), .W(PER_W)) i_loEnc   (.req(loLive),   .hit(loHit),   .idx(loIdx));
  irq_prio_enc #(.N(PER_N), .W(PER_W)) i_normEnc (.req(normLive), .hit(normHit), .idx(normIdx));

  assign perHit = hiHit | loHit | normHit;
  always_comb begin
    if (hiHit)      perIdx = hiIdx;
    else if (loHit) perIdx = loIdx;
    else            perIdx = normIdx;
  end

  // Critical group: slot CRIT_BOOST_SLOT carries the high-boost aggregate
  logic [CRIT_SLOTS-1:0] critSlots;
  for (genvar s = 0; s < CRIT_SLOTS; s++) begin : g_critSlot
    if (s == CRIT_BOOST_SLOT) begin : g_boost
      assign critSlots[s] = hiHit;
    end else if (s < CRIT_BOOST_SLOT) begin : g_low
      assign critSlots[s] = critQ[s];
    end else begin : g_high
      assign critSlots[s] = critQ[s-1];
    end
  end

  // Main group: slot MAIN_BOOST_SLOT carries the low-boost aggregate, mask bit 16-n
  logic [MAIN_SLOTS-1:0] mainSlots, mainLive;
  for (genvar s = 0; s < MAIN_SLOTS; s++) begin : g_mainSlot
    if (s == MAIN_BOOST_SLOT) begin : g_boost
      assign mainSlots[s] = loHit;
    end else if (s < MAIN_BOOST_SLOT) begin : g_low
      assign mainSlots[s] = mainQ[s];
    end else begin : g_high
      assign mainSlots[s] = mainQ[s-1];
    end
    assign mainLive[s] = mainSlots[s] & ~mainMaskQ[MAIN_SLOTS-1-s];
  end

  logic              critHit, mainHit;
  logic [CRIT_W-1:0] critIdx;
  logic [MAIN_W-1:0] mainIdx;

  irq_prio_enc #(.N(CRIT_SLOTS), .W(CRIT_W)) i_critEnc (.req(critSlots), .hit(critHit), .idx(critIdx));
  irq_prio_enc #(.N(MAIN_SLOTS), .W(MAIN_W)) i_mainEnc (.req(mainLive),  .hit(mainHit), .idx(mainIdx));

  always_comb begin
    statusWord = '0;
    statusWord[CRIT_FLAG_BIT] = critHit;
    statusWord[MAIN_FLAG_BIT] = mainHit;
    statusWord[PER_FLAG_BIT]  = perHit;
    statusWord[CRIT_CODE_LSB +: CRIT_FIELD_W] = CRIT_FIELD_W'(critIdx);
    statusWord[MAIN_CODE_LSB +: MAIN_FIELD_W] = MAIN_FIELD_W'(mainIdx);
    statusWord[PER_CODE_LSB  +: PER_FIELD_W]  = PER_FIELD_W'(perIdx);
  end

  assign cpuIrq = critHit | mainHit | perHit;

  // R5: a main mask write lands in the register on the next edge
  p_mask_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMainMask |=> (mainMaskQ == $past(strb.wdata[MAIN_SLOTS-1:0])));

  // R8: with slot 0 disabled, a reported main code is never 0
  p_masked_slot_r8: assert property (@(posedge clk) disable iff (!rstN)
    (mainMaskQ[MAIN_SLOTS-1] && statusWord[MAIN_FLAG_BIT])
      |-> (statusWord[MAIN_CODE_LSB +: MAIN_FIELD_W] != '0));

  // R7: the high-boost critical code implies a pending peripheral
  p_boost_hi_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[CRIT_FLAG_BIT] &&
     statusWord[CRIT_CODE_LSB +: CRIT_FIELD_W] == CRIT_FIELD_W'(CRIT_BOOST_SLOT))
      |-> statusWord[PER_FLAG_BIT]);

  // R1: a clear peripheral flag leaves its code at zero
  p_per_code_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !statusWord[PER_FLAG_BIT] |-> (statusWord[PER_CODE_LSB +: PER_FIELD_W] == '0));

  // R9: no captured request means no processor interrupt
  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (critQ == '0 && mainQ == '0 && perQ == '0) |-> !cpuIrq);
endmodule

// File: rtl/irq_group_encoder.sv
module irq_group_encoder
  import irq_enc_pkg::*;
#(
  parameter int               CRIT_N        = 3,
  parameter int               MAIN_N        = 16,
  parameter int               PER_N         = 32,
  parameter logic [PER_N-1:0] HI_BOOST      = 'h2,
  parameter logic [PER_N-1:0] LO_BOOST      = 'h4,
  parameter logic [31:0]      MAIN_MASK_RST = 32'h0001_0fff,
  parameter logic [31:0]      PER_MASK_RST  = 32'h7fff_fc00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [CRIT_N-1:0] critReq,
  input  logic [MAIN_N-1:0] mainReq,
  input  logic [PER_N-1:0]  perReq,
  output logic              cpuIrq
);
  localparam int MAIN_SLOTS = MAIN_N + 1;
  localparam logic [REG_W-1:0] FLAG_BITS =
    (REG_W'(1) << CRIT_FLAG_BIT) | (REG_W'(1) << MAIN_FLAG_BIT) | (REG_W'(1) << PER_FLAG_BIT);

  regStrobes_t           strb;
  logic [MAIN_SLOTS-1:0] mainMaskQ;
  logic [REG_W-1:0]      perMaskQ;
  logic [REG_W-1:0]      statusWord;

  irq_enc_ctrl #(.MAIN_SLOTS(MAIN_SLOTS)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata), .busRdata(busRdata),
    .mainMaskQ(mainMaskQ), .perMaskQ(perMaskQ), .statusWord(statusWord), .strb(strb)
  );

  irq_enc_datapath #(
    .CRIT_N(CRIT_N), .MAIN_N(MAIN_N), .PER_N(PER_N),
    .HI_BOOST(HI_BOOST), .LO_BOOST(LO_BOOST),
    .MAIN_MASK_RST(MAIN_MASK_RST), .PER_MASK_RST(PER_MASK_RST)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .critReq(critReq), .mainReq(mainReq), .perReq(perReq),
    .mainMaskQ(mainMaskQ), .perMaskQ(perMaskQ), .statusWord(statusWord), .cpuIrq(cpuIrq)
  );

  // R9: the interrupt line agrees with the flags read from the status address
  p_irq_matches_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_STATUS) |-> (cpuIrq == |(busRdata & FLAG_BITS)));
endmodule

// File: tb/test_irq_group_encoder.sv
module test_irq_group_encoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [2:0]  critReq = '0;
  logic [15:0] mainReq = '0;
  logic [31:0] perReq = '0;
  logic        cpuIrq;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_group_encoder i_irq_group_encoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWdata(busWdata),
    .busRdata(busRdata), .critReq(critReq), .mainReq(mainReq), .perReq(perReq), .cpuIrq(cpuIrq)
  );

  // Vector table: main mask, peripheral mask, requests, expected status word
  localparam int NV = 14;
  localparam logic [16:0] V_MMASK [NV] = '{17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0, 17'h0,
                                            17'h0, 17'h0, 17'h10000, 17'h01000, 17'h1ffff, 17'h0, 17'h0};
  localparam logic [31:0] V_PMASK [NV] = '{32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                            32'h0, 32'h0, 32'h8000_0000, 32'h0, 32'hffff_ffff, 32'h0, 32'h0};
  localparam logic [2:0]  V_CRIT  [NV] = '{3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b100, 3'b000,
                                            3'b000, 3'b001, 3'b000, 3'b000, 3'b000, 3'b110, 3'b000};
  localparam logic [15:0] V_MAIN  [NV] = '{16'h0, 16'h0, 16'h0, 16'h0001, 16'h0010, 16'h8000, 16'h0,
                                            16'h0, 16'h0, 16'h0003, 16'h0, 16'hffff, 16'h0006, 16'h0008};
  localparam logic [31:0] V_PER   [NV] = '{32'h0, 32'h1, 32'h20, 32'h20, 32'h0, 32'h0, 32'h3,
                                            32'h4, 32'h2, 32'h9, 32'h4, 32'hffff_ffff, 32'h30, 32'h4};
  localparam logic [31:0] V_EXP   [NV] = '{32'h0000_0000,  // R1 idle
                                            32'h2000_0000,  // R1 peripheral 0
                                            32'h2500_0000,  // R1 peripheral 5
                                            32'h2520_0000,  // R1 two groups at once
                                            32'h0025_0000,  // R4 main input 4 -> slot 5
                                            32'h0030_0700,  // R3 crit input 2 -> slot 3, R4 input 15 -> slot 16
                                            32'h2100_0600,  // R7 high boost beats normal peripheral 0
                                            32'h2224_0000,  // R7 low boost -> main slot 4
                                            32'h2100_0400,  // R3 crit slot 0 beats boost slot 2
                                            32'h2321_0000,  // R8 masked slot 0 / source 0 skipped
                                            32'h2200_0000,  // R7 main mask gates slot 4 only
                                            32'h0000_0000,  // R8 everything masked
                                            32'h2421_0500,  // R2 lowest number wins in each group
                                            32'h2223_0000}; // R2 slot 3 beats boost slot 4
  localparam int V_REQ [NV] = '{1, 1, 1, 1, 4, 3, 7, 7, 3, 8, 7, 8, 2, 2};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] addr, logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] addr, output logic [31:0] data);
    busAddr = addr;
    #1 data = busRdata;
  endtask

  task automatic applyReqs(logic [2:0] c, logic [15:0] m, logic [31:0] p);
    @(negedge clk);
    critReq = c; mainReq = m; perReq = p;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state: R5, R6, R9
    busRead(2'd0, rd); check("R5 main mask reset", rd, 32'h0001_0fff);
    busRead(2'd1, rd); check("R6 peripheral mask reset", rd, 32'h7fff_fc00);
    busRead(2'd2, rd); check("R1 status reset", rd, 32'h0);
    check("R9 irq low after reset", 32'(cpuIrq), 32'h0);

    // Reset mask values act on the sources: R6, R5
    applyReqs(3'b000, 16'h0001, 32'h2);
    busRead(2'd2, rd); check("R6 source 1 and main slot 0 disabled at reset", rd, 32'h0);
    check("R9 irq low when all masked", 32'(cpuIrq), 32'h0);
    applyReqs(3'b000, 16'h0, 32'h0040_0000);
    busRead(2'd2, rd); check("R6 source 22 enabled at reset", rd, 32'h3600_0000);
    applyReqs(3'b000, 16'h0, 32'h0);

    // R10: status and spare addresses
    busWrite(2'd2, 32'hffff_ffff);
    busRead(2'd0, rd); check("R10 status write leaves main mask", rd, 32'h0001_0fff);
    busRead(2'd1, rd); check("R10 status write leaves peripheral mask", rd, 32'h7fff_fc00);
    busRead(2'd2, rd); check("R10 status unchanged by write", rd, 32'h0);
    busWrite(2'd3, 32'hffff_ffff);
    busRead(2'd3, rd); check("R10 spare address reads zero", rd, 32'h0);

    // R5: unused upper bits
    busWrite(2'd0, 32'hffff_ffff);
    busRead(2'd0, rd); check("R5 main mask width", rd, 32'h0001_ffff);

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      busWrite(2'd0, 32'(V_MMASK[v]));
      busWrite(2'd1, V_PMASK[v]);
      applyReqs(V_CRIT[v], V_MAIN[v], V_PER[v]);
      busRead(2'd2, rd);
      check($sformatf("R%0d vector %0d status", V_REQ[v], v), rd, V_EXP[v]);
      check($sformatf("R9 vector %0d irq", v), 32'(cpuIrq), 32'(V_EXP[v] != 0));
    end

    // R9: one-edge latency on request rise and fall
    applyReqs(3'b000, 16'h0, 32'h0);
    busWrite(2'd0, 32'h0);
    busWrite(2'd1, 32'h0);
    @(negedge clk);
    perReq = 32'h1;
    #1 check("R9 irq not yet raised before edge", 32'(cpuIrq), 32'h0);
    @(negedge clk);
    check("R9 irq raised after edge", 32'(cpuIrq), 32'h1);
    perReq = 32'h0;
    #1 check("R9 irq held until edge", 32'(cpuIrq), 32'h1);
    @(negedge clk);
    check("R9 irq dropped after edge", 32'(cpuIrq), 32'h0);

    // R8/R9: masking a pending source drops the line
    applyReqs(3'b000, 16'h0, 32'h1);
    check("R9 irq with source 0 pending", 32'(cpuIrq), 32'h1);
    busWrite(2'd1, 32'h8000_0000);
    check("R8 irq dropped once source 0 masked", 32'(cpuIrq), 32'h0);
    busRead(2'd2, rd); check("R8 masked source hidden", rd, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule